// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This block gives a host that accesses registers in 64-bit words a way to reach a narrower 32-bit register bus behind it. The host writes one 64-bit command word. That word holds an operation code, a 13-bit register address and 32 bits of write data. The bridge then runs exactly one read or write on the internal bus and reports completion through a status word that the host polls.

The internal side uses a request/acknowledge handshake. The request carries the address, the write enable and the write data. The acknowledge returns the read data. A third host location is a fixed capability word. It tells software how the serial peripheral master that sits behind the register bus is configured. Completion is reported only by the valid flag in the status word; the block has no interrupt.

Top module: `regbus_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, the bridge clears the status valid flag, the status data field and any outstanding request. After reset, `bus_req` is 0 and the status word reads 0.
- R2: A host write to offset 0x10 with bits 63:62 equal to 1 starts a read. `bus_addr` equals command bits 44:32, zero-extended, and `bus_we` is 0. Command bits 61:45 have no effect.
- R3: A host write to offset 0x10 with bits 63:62 equal to 2 starts a write. `bus_we` is 1 and `bus_wdata` equals command bits 31:0.
- R4: An operation code of 0 or 3 starts no bus request and leaves the status word unchanged.
- R5: Once raised, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold steady until the clock edge at which `bus_ack` is sampled high.
- R6: Accepting a command clears the valid flag (status bit 32). The flag is set in the cycle after the edge that samples `bus_req` and `bus_ack` both high, and `bus_req` drops at that same edge.
- R7: Status bits 31:0, read at offset 0x18, load the `bus_rdata` value present at a read's acknowledge edge. They keep that value until the next read completes; a completed write leaves them unchanged. Status bits 63:33 read 0.
- R8: A command written while a request is outstanding is ignored. The outstanding request and the status word are unchanged, and no further bus transaction follows.
- R9: Offset 0x08 reads a constant capability word. Its fields are: bit 1 shift order (1 = LSB first), bits 7:2 transfer width, bits 13:8 chip-select count, bit 14 clock polarity, bit 15 clock phase, and bits 47:32 peripheral identifier. All other bits read 0.
- R10: Offsets other than 0x08 and 0x18, including the command offset 0x10, read as 0. Host writes to any offset other than 0x10 have no effect.
- R11: `bus_req` rises in the cycle after the edge that samples the command write, so a transaction whose acknowledge comes back at once is visible as valid on the second status poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, combinational from `host_addr` |
| bus_req | output | 1 | Internal bus request |
| bus_addr | output | BUS_AW | Internal bus register address |
| bus_we | output | 1 | Internal bus write enable |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_rdata | input | 32 | Internal bus read data, valid with `bus_ack` |

## Verification
The outstanding flag is the one piece of internal state that matters. If it is wrong, the error reaches the ports within a cycle:
- a missing busy bit drops `bus_req` early or accepts a second command;
- a stuck busy bit keeps the request up after the acknowledge;
- a wrong completion update shows as a status valid bit or data field that differs on the very next poll.

Because the bench compares every output on every clock against a behavioural model, any such divergence is reported in the cycle it first appears. The error cannot hide until a later transaction.

// File: rtl/regbus_bridge.sv
module regbus_bridge #(
  parameter int          HOST_AW   = 8,
  parameter int          REG_AW    = 13,
  parameter int          BUS_AW    = 32,
  parameter bit          LSB_FIRST = 1'b0,
  parameter int          XFER_BITS = 32,
  parameter int          NUM_CS    = 1,
  parameter bit          CPOL      = 1'b0,
  parameter bit          CPHA      = 1'b0,
  parameter logic [15:0] PERIPH_ID = 16'h0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               bus_req,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic               bus_we,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [31:0]        bus_rdata
);
  localparam logic [HOST_AW-1:0] OFF_CAP = HOST_AW'(8);
  localparam logic [HOST_AW-1:0] OFF_CMD = HOST_AW'(16);
  localparam logic [HOST_AW-1:0] OFF_STS = HOST_AW'(24);
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_WR = 2'd2;

  logic              busy, done, we_q;
  logic [REG_AW-1:0] addr_q;
  logic [31:0]       wd_q, rd_q;
  logic [63:0]       cap_word, sts_word;

  wire [1:0] op     = host_wdata[63:62];
  wire       launch = host_wr && host_addr == OFF_CMD && !busy && (op == OP_RD || op == OP_WR);
  wire       finish = busy && bus_ack;
  wire       unused_cmd_bits = ^host_wdata[61:32+REG_AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      rd_q <= '0;
    end else if (finish) begin
      busy <= 1'b0;
      done <= 1'b1;
      if (!we_q) rd_q <= bus_rdata;
    end else if (launch) begin
      busy <= 1'b1;
      done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      addr_q <= host_wdata[32 +: REG_AW];
      we_q   <= op == OP_WR;
      wd_q   <= host_wdata[31:0];
    end
  end

  assign bus_req   = busy;
  assign bus_addr  = {{(BUS_AW-REG_AW){1'b0}}, addr_q};
  assign bus_we    = we_q;
  assign bus_wdata = wd_q;

  always_comb begin
    cap_word        = '0;
    cap_word[1]     = LSB_FIRST;
    cap_word[7:2]   = 6'(XFER_BITS);
    cap_word[13:8]  = 6'(NUM_CS);
    cap_word[14]    = CPOL;
    cap_word[15]    = CPHA;
    cap_word[47:32] = PERIPH_ID;
    sts_word        = '0;
    sts_word[31:0]  = rd_q;
    sts_word[32]    = done;
  end

  always_comb begin
    case (host_addr)
      OFF_CAP: host_rdata = cap_word;
      OFF_STS: host_rdata = sts_word;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/regbus_bridge_chk.sv
module regbus_bridge_chk #(
  parameter int BUS_AW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              done,
  input logic [31:0]       rd_q
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && !done));

  assert_hold_request_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_complete_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> (!bus_req && done));

  assert_clear_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !done);

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_ack && !bus_we) |=> $stable(rd_q));
endmodule

bind regbus_bridge regbus_bridge_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .rd_q(rd_q)
);

// File: tb/test_regbus_bridge.sv
module test_regbus_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = 8'h18;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0, fails = 0, lat = 0, cnt = 0;

  // capability expected: PID BEEF in 47:32, CPOL=1 (bit14), 3 CS (13:8), width 32 (7:2), LSB first (bit1)
  localparam logic [63:0] CAP_EXP = 64'h0000_BEEF_0000_4382;

  regbus_bridge #(.LSB_FIRST(1'b1), .XFER_BITS(32), .NUM_CS(3), .CPOL(1'b1),
                  .CPHA(1'b0), .PERIPH_ID(16'hBEEF)) i_regbus_bridge (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  function automatic logic [31:0] initv(int i);
    return (i * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  logic [31:0] mem [8192];
  initial for (int i = 0; i < 8192; i++) mem[i] = initv(i);

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic        m_busy = 0, m_valid = 0, m_we = 0;
  logic [31:0] m_rd = 0, m_wd = 0;
  logic [12:0] m_addr = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_valid <= 0; m_rd <= 0;
    end else if (m_busy && bus_ack) begin
      m_busy <= 0; m_valid <= 1;
      if (m_we) mem[m_addr] <= m_wd; else m_rd <= bus_rdata;
    end else if (!m_busy && host_wr && host_addr == 8'h10 &&
                 (host_wdata[63:62] == 2'd1 || host_wdata[63:62] == 2'd2)) begin
      m_busy <= 1; m_valid <= 0;
      m_addr <= host_wdata[44:32]; m_we <= host_wdata[63:62] == 2'd2; m_wd <= host_wdata[31:0];
    end
  end

  function automatic logic [63:0] exp_rd();
    case (host_addr)
      8'h08:   return CAP_EXP;
      8'h18:   return {31'b0, m_valid, m_rd};
      default: return 64'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk(bus_req === m_busy, "R11 request timing", 64'(bus_req), 64'(m_busy));
      if (m_busy && bus_req) begin
        chk(bus_addr === {19'b0, m_addr}, "R2 bus address", 64'(bus_addr), 64'({19'b0, m_addr}));
        chk(bus_we === m_we, "R3 write enable", 64'(bus_we), 64'(m_we));
        if (m_we) chk(bus_wdata === m_wd, "R3 write data", 64'(bus_wdata), 64'(m_wd));
      end
      chk(host_rdata === exp_rd(), "R6/R7/R9/R10 host readback", host_rdata, exp_rd());
    end
  end

  // internal bus responder
  always @(negedge clk) begin
    if (bus_req) begin
      if (cnt >= lat) begin
        bus_ack <= 1'b1; bus_rdata <= mem[bus_addr[12:0]];
      end else begin
        bus_ack <= 1'b0; bus_rdata <= 32'hDEAD_0000 | 32'(cnt); cnt <= cnt + 1;
      end
    end else begin
      bus_ack <= 1'b0; bus_rdata <= 32'hBAD0_BAD0; cnt <= 0;
    end
  end

  task automatic host_write(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 8'h18;
  endtask

  task automatic cmd(logic [1:0] op, logic [12:0] a, logic [31:0] d, logic [16:0] junk);
    host_write(8'h10, {op, junk, a, d});
  endtask

  task automatic wait_done(string tag);
    int polls = 0;
    do begin
      @(posedge clk); #2; polls++;
    end while (!host_rdata[32] && polls < 50);
    chk(polls < 50, tag, 64'(polls), 64'd50);
  endtask

  task automatic idle_check(logic [63:0] saved, string tag);
    repeat (4) begin
      @(posedge clk); #2;
      chk(bus_req === 1'b0, tag, 64'(bus_req), 64'h0);
    end
    chk(host_rdata === saved, tag, host_rdata, saved);
  endtask

  logic [63:0] saved;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    chk(bus_req === 1'b0, "R1 no request after reset", 64'(bus_req), 64'h0);
    chk(host_rdata === 64'h0, "R1 status cleared", host_rdata, 64'h0);

    // write then read back
    lat = 0;
    cmd(2'd2, 13'h004, 32'hA5A5_1234, 17'h0);
    #1;
    chk(bus_req === 1'b1 && bus_we === 1'b1, "R3 write launched", {bus_req, bus_we}, 2'b11);
    wait_done("R11 write latency");
    chk(host_rdata === 64'h1_0000_0000, "R7 write keeps data", host_rdata, 64'h1_0000_0000);
    lat = 2;
    cmd(2'd1, 13'h004, 32'hFFFF_FFFF, 17'h0);
    #1;
    chk(host_rdata[32] === 1'b0, "R6 valid cleared on launch", 64'(host_rdata[32]), 64'h0);
    wait_done("R11 read latency");
    chk(host_rdata === {32'h1, 32'hA5A5_1234}, "R2 read data", host_rdata, {32'h1, 32'hA5A5_1234});

    // no-op codes
    saved = host_rdata;
    cmd(2'd0, 13'h008, 32'h1111_1111, 17'h0);
    idle_check(saved, "R4 opcode 0 ignored");
    cmd(2'd3, 13'h008, 32'h2222_2222, 17'h0);
    idle_check(saved, "R4 opcode 3 ignored");

    // writes to non-command offsets
    host_write(8'h18, {2'd2, 17'h0, 13'h00C, 32'h3333_3333});
    host_write(8'h08, {2'd1, 17'h0, 13'h00C, 32'h0});
    host_write(8'h00, {2'd2, 17'h0, 13'h00C, 32'h4444_4444});
    idle_check(saved, "R10 other offsets ignored");

    // capability and unmapped reads
    @(negedge clk); host_addr = 8'h08; #1;
    chk(host_rdata === CAP_EXP, "R9 capability word", host_rdata, CAP_EXP);
    @(negedge clk); host_addr = 8'h10; #1;
    chk(host_rdata === 64'h0, "R10 command reads zero", host_rdata, 64'h0);
    @(negedge clk); host_addr = 8'h20; #1;
    chk(host_rdata === 64'h0, "R10 unmapped reads zero", host_rdata, 64'h0);
    @(negedge clk); host_addr = 8'h18;

    // command while outstanding
    lat = 6;
    cmd(2'd1, 13'h010, 32'h0, 17'h0);
    cmd(2'd2, 13'h020, 32'h5555_5555, 17'h0);
    wait_done("R8 first transaction completes");
    chk(host_rdata[31:0] === initv(16), "R8 first read data", 64'(host_rdata[31:0]), 64'(initv(16)));
    idle_check(host_rdata, "R8 no second transaction");
    lat = 0;
    cmd(2'd1, 13'h020, 32'h0, 17'h0);
    wait_done("R8 readback");
    chk(host_rdata[31:0] === initv(32), "R8 ignored write left target", 64'(host_rdata[31:0]), 64'(initv(32)));

    // highest address with junk in upper command bits
    lat = 1;
    cmd(2'd1, 13'h1FFF, 32'h0, 17'h1FFFF);
    #1;
    chk(bus_addr === 32'h0000_1FFF, "R2 address zero-extended", 64'(bus_addr), 64'h1FFF);
    wait_done("R2 high address");
    chk(host_rdata[31:0] === initv(8191), "R2 high address data", 64'(host_rdata[31:0]), 64'(initv(8191)));

    // mixed traffic
    for (int k = 0; k < 30; k++) begin
      logic [12:0] a;
      a = 13'((k % 6) * 4);
      lat = (k * 7) % 5;
      if (k % 3 == 0) cmd(2'd2, a, 32'(k) * 32'h0101_0101 ^ 32'hC0FF_EE00, 17'(k));
      else            cmd(2'd1, a, 32'h0, 17'(k));
      wait_done("R11 mixed latency");
      if (k % 3 != 0)
        chk(host_rdata[31:0] === mem[a], "R7 mixed read data", 64'(host_rdata[31:0]), 64'(mem[a]));
    end

    // reset during an outstanding request
    lat = 20;
    cmd(2'd1, 13'h004, 32'h0, 17'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk(bus_req === 1'b0, "R1 reset drops request", 64'(bus_req), 64'h0);
    chk(host_rdata === 64'h0, "R1 reset clears status", host_rdata, 64'h0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule